// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the register window through which a host processor hands commands to a service microcontroller. The host has a small memory-mapped slave port. Writing a command word starts a transaction: the block marks itself busy and sends a one-cycle doorbell pulse to the controller. Before that, the host may stage up to sixteen bytes of arguments in an outbound buffer. The host then polls a status word until busy drops. Once busy is low, the host reads the error indication and any reply bytes that the controller placed in an inbound buffer.

The controller has its own side-band port. On that port it sees the latched command word and can read any outbound buffer word by index. It writes inbound buffer words, and it ends a transaction with a done strobe that carries an error flag and an 8-bit error code. A command can request a completion interrupt. In that case the host gets a single-cycle pulse when the controller finishes, so there is no flag to clear.

Top module: `cmd_mailbox`

## Requirements
- R1: A host write to offset 0x00 while busy is low is accepted. From the next cycle, busy (status bit 0) reads 1, `c_cmd` holds the written word, and `c_doorbell` is high for exactly one cycle.
- R2: Status at offset 0x04 has this layout: bit 0 busy, bit 1 error, bit 2 overrun, bit 3 zero, bits 7:4 command id, bits 15:8 the `INIT_ID` parameter (default 0x5A), bits 23:16 error code, and bits 31:24 zero.
- R3: Status bits 7:4 hold bits 15:12 of the most recently accepted command word.
- R4: A done strobe while busy clears busy from the next cycle. The same strobe loads the error bit from `c_done_err` and the error code from `c_done_code`. Accepting a new command clears the error bit and the error code.
- R5: If bit 8 of the accepted command is 1, a done strobe while busy makes `h_irq` high for exactly one cycle, in the cycle after the strobe. If bit 8 is 0, `h_irq` stays low.
- R6: A command write while busy is ignored: `c_cmd` and the command id do not change and no doorbell pulse is sent. The write also sets the overrun bit, which stays set until reset.
- R7: A host word write at offset 0x80+4k (k = 0..3) stores that word in outbound slot k, and the controller reads it on `c_wb_word` when `c_wb_idx` = k.
- R8: Controller writes to inbound slot k are read by the host as a word at 0x90+4k. A host read with `h_byte` = 1 in this range returns byte lane `h_addr[1:0]`, zero-extended.
- R9: Host reads of offset 0x00 and of the outbound buffer return 0. Host writes to offset 0x04 and to the inbound buffer change nothing.
- R10: A done strobe while busy is low changes no status field and produces no `h_irq`.
- R11: After reset, busy, error, overrun, command id and error code are zero, and `c_cmd` and both buffers are zero.
- R12: If a done strobe and a command write fall in the same busy cycle, the done strobe completes the old command, and the new command is rejected as an overrun under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe; read data is combinational |
| h_byte | input | 1 | Host byte read for the inbound buffer |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, zero when not reading |
| h_irq | output | 1 | Completion pulse to host |
| c_cmd | output | 32 | Latched command word |
| c_doorbell | output | 1 | New-command pulse to controller |
| c_wb_idx | input | 2 | Outbound slot selected by controller |
| c_wb_word | output | 32 | Outbound slot contents |
| c_rb_we | input | 1 | Controller inbound write strobe |
| c_rb_idx | input | 2 | Inbound slot written |
| c_rb_wdata | input | 32 | Inbound write data |
| c_done | input | 1 | Command finished strobe |
| c_done_err | input | 1 | Error flag carried by done |
| c_done_code | input | 8 | Error code carried by done |

## Verification
A controller done strobe and a host command write can land on the same clock edge while busy is set. The bench provokes this by issuing a command with completion interrupt enabled and then driving both strobes in one cycle. It judges the result by several observations. The old command must finish: busy must read low, the error code must come from the strobe, and one completion pulse must arrive. The new word must be refused: `c_cmd` keeps the old value, no extra doorbell pulse appears, and overrun is set.

// File: rtl/mbx_pkg.sv
// Shared layout of the mailbox command word and host offsets.
// Assumes a 32-bit data path and byte addressing on the host port.
package mbx_pkg;
    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] size;
        logic [3:0] id;
        logic [2:0] rsv_lo;
        logic       ioc;
        logic [7:0] op;
    } cmd_word_t;

    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_WBUF = 8'h80;
endpackage

// File: rtl/mbx_cmd_ctl.sv
// Command handshake: latches accepted commands, tracks busy, error and
// overrun, and emits the doorbell and completion pulses.
// Assumes cmd_wr and done are single-cycle strobes from the top decode.
module mbx_cmd_ctl
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  cmd_word_t  cmd_word,
    input  logic       done,
    input  logic       done_err,
    input  logic [7:0] done_code,
    output logic       busy,
    output logic       err,
    output logic [7:0] code,
    output logic       overrun,
    output cmd_word_t  cmd_q,
    output logic       doorbell,
    output logic       cpl_irq
);
    // Busy flag, latched command and completion result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            err   <= 1'b0;
            code  <= '0;
            cmd_q <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                err  <= done_err;
                code <= done_code;
            end
        end else if (cmd_wr) begin
            busy  <= 1'b1;
            cmd_q <= cmd_word;
            err   <= 1'b0;
            code  <= '0;
        end
    end

    // Sticky overrun on a command write that arrives while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (busy && cmd_wr)
            overrun <= 1'b1;
    end

    // One-cycle pulses toward controller and host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doorbell <= 1'b0;
            cpl_irq  <= 1'b0;
        end else begin
            doorbell <= !busy && cmd_wr;
            cpl_irq  <= busy && done && cmd_q.ioc;
        end
    end
endmodule

// File: rtl/mbx_wbuf.sv
// Outbound buffer: host writes words, controller reads any word by index.
// Assumes the host index is already range-checked by the caller.
module mbx_wbuf #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        // Holds one outbound word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (wr && wr_idx == IDX_W'(g))
                slot[g] <= wr_data;
        end
    end

    assign rd_data = slot[rd_idx];
endmodule

// File: rtl/mbx_rbuf.sv
// Inbound buffer: controller writes words, host reads a word or one byte.
// Assumes byte lane select comes from the host address low bits.
module mbx_rbuf #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_byte,
    input  logic [LANE_W-1:0] rd_lane,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [WORDS];
    logic [DATA_W-1:0] word;

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        // Holds one inbound word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (wr && wr_idx == IDX_W'(g))
                slot[g] <= wr_data;
        end
    end

    assign word = slot[rd_idx];

    // Word read or zero-extended byte lane.
    always_comb begin
        if (rd_byte)
            rd_data = DATA_W'(word[rd_lane*8 +: 8]);
        else
            rd_data = word;
    end
endmodule

// File: rtl/cmd_mailbox.sv
// Host/controller command mailbox top: decodes the host window, builds
// the status word and joins the control and buffer blocks.
// Assumes single-beat host accesses with combinational read data.
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int         DATA_W    = 32,
    parameter int         ADDR_W    = 8,
    parameter int         BUF_BYTES = 16,
    parameter logic [7:0] INIT_ID   = 8'h5A,
    localparam int WORDS  = BUF_BYTES / 4,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr_en,
    input  logic              h_rd_en,
    input  logic              h_byte,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    output logic [DATA_W-1:0] c_cmd,
    output logic              c_doorbell,
    input  logic [IDX_W-1:0]  c_wb_idx,
    output logic [DATA_W-1:0] c_wb_word,
    input  logic              c_rb_we,
    input  logic [IDX_W-1:0]  c_rb_idx,
    input  logic [DATA_W-1:0] c_rb_wdata,
    input  logic              c_done,
    input  logic              c_done_err,
    input  logic [7:0]        c_done_code
);
    localparam logic [ADDR_W-1:0] WB_LO = ADDR_W'(OFS_WBUF);
    localparam logic [ADDR_W-1:0] RB_LO = ADDR_W'(int'(OFS_WBUF) + BUF_BYTES);
    localparam logic [ADDR_W-1:0] RB_HI = ADDR_W'(int'(OFS_WBUF) + 2 * BUF_BYTES - 1);

    logic              in_cmd, in_stat, in_wb, in_rb;
    logic              busy, err, overrun;
    logic [7:0]        code;
    cmd_word_t         cmd_q;
    logic [DATA_W-1:0] stat_word, rb_rdata;
    logic [IDX_W-1:0]  h_idx;

    // Host address regions.
    assign in_cmd  = h_addr == ADDR_W'(OFS_CMD);
    assign in_stat = h_addr == ADDR_W'(OFS_STAT);
    assign in_wb   = h_addr >= WB_LO && h_addr < RB_LO;
    assign in_rb   = h_addr >= RB_LO && h_addr <= RB_HI;
    assign h_idx   = h_addr[IDX_W+1:2];

    mbx_cmd_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (h_wr_en && in_cmd),
        .cmd_word (cmd_word_t'(h_wdata)),
        .done     (c_done),
        .done_err (c_done_err),
        .done_code(c_done_code),
        .busy     (busy),
        .err      (err),
        .code     (code),
        .overrun  (overrun),
        .cmd_q    (cmd_q),
        .doorbell (c_doorbell),
        .cpl_irq  (h_irq)
    );

    mbx_wbuf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_wbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (h_wr_en && in_wb),
        .wr_idx (h_idx),
        .wr_data(h_wdata),
        .rd_idx (c_wb_idx),
        .rd_data(c_wb_word)
    );

    mbx_rbuf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_rbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (c_rb_we),
        .wr_idx (c_rb_idx),
        .wr_data(c_rb_wdata),
        .rd_idx (h_idx),
        .rd_byte(h_byte),
        .rd_lane(h_addr[1:0]),
        .rd_data(rb_rdata)
    );

    // Status word assembly.
    assign stat_word = DATA_W'({8'h00, code, INIT_ID, cmd_q.id, 1'b0, overrun, err, busy});
    assign c_cmd     = DATA_W'(cmd_q);

    // Host read mux; write-only and unmapped offsets return zero.
    always_comb begin
        h_rdata = '0;
        if (h_rd_en) begin
            if (in_stat)    h_rdata = stat_word;
            else if (in_rb) h_rdata = rb_rdata;
        end
    end
endmodule

// File: rtl/mbx_checker.sv
// Protocol properties of the mailbox, attached to the top by bind.
// Assumes stat carries the status word layout of the top module.
module mbx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        h_wr_en,
    input logic [7:0]  h_addr,
    input logic        c_done,
    input logic        c_doorbell,
    input logic        h_irq,
    input logic [31:0] stat
);
    logic cmd_wr;
    assign cmd_wr = h_wr_en && h_addr == 8'h00;

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !stat[0]) |=> (stat[0] && c_doorbell));            // R1
    AST_BELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        c_doorbell |=> !c_doorbell);                                  // R1
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && stat[0]) |=> (!c_doorbell && stat[2]));            // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat[2] |=> stat[2]);                                         // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_done && stat[0]) |=> !stat[0]);                            // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        h_irq |-> $past(c_done && stat[0]));                          // R5
    AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_done && !stat[0] && !cmd_wr) |=> ($stable(stat) && !h_irq)); // R10
endmodule

bind cmd_mailbox mbx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_wr_en   (h_wr_en),
    .h_addr    (h_addr),
    .c_done    (c_done),
    .c_doorbell(c_doorbell),
    .h_irq     (h_irq),
    .stat      (stat_word)
);

// File: tb/sim_cmd_mailbox.sv
`timescale 1ns/1ps
module sim_cmd_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr_en = 1'b0, h_rd_en = 1'b0, h_byte = 1'b0;
    logic [7:0]  h_addr = '0;
    logic [31:0] h_wdata = '0, h_rdata;
    logic        h_irq, c_doorbell;
    logic [31:0] c_cmd, c_wb_word;
    logic [1:0]  c_wb_idx = '0, c_rb_idx = '0;
    logic        c_rb_we = 1'b0;
    logic [31:0] c_rb_wdata = '0;
    logic        c_done = 1'b0, c_done_err = 1'b0;
    logic [7:0]  c_done_code = '0;

    int n_cmp = 0, n_bad = 0, n_bell = 0, n_irq = 0;
    bit finished = 0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    cmd_mailbox u0 (.*);

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: counts pulses and compares host read data against the scoreboard.
    initial forever begin
        @(negedge clk); #1;
        if (c_doorbell) n_bell++;
        if (h_irq) n_irq++;
        if (h_rd_en) begin
            item_t it;
            it = sb.pop_front();
            check(h_rdata, it.exp, it.tag);
        end
    end

    task automatic hread(input logic [7:0] a, input logic bt, input logic [31:0] exp, input string tag);
        @(negedge clk);
        h_addr = a; h_byte = bt; h_rd_en = 1'b1;
        sb.push_back('{exp, tag});
        @(negedge clk);
        h_rd_en = 1'b0; h_byte = 1'b0;
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        h_addr = a; h_wdata = d; h_wr_en = 1'b1;
        @(negedge clk);
        h_wr_en = 1'b0;
    endtask

    task automatic cdone(input logic e, input logic [7:0] c, input logic with_cmd, input logic [31:0] d);
        @(negedge clk);
        c_done = 1'b1; c_done_err = e; c_done_code = c;
        if (with_cmd) begin h_addr = 8'h00; h_wdata = d; h_wr_en = 1'b1; end
        @(negedge clk);
        c_done = 1'b0; h_wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #2;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        int b0, i0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        #1;
        check({31'b0, c_doorbell}, 0, "R11 doorbell");
        check({31'b0, h_irq}, 0, "R11 irq");
        check(c_cmd, 0, "R11 cmd");
        check(c_wb_word, 0, "R11 wbuf");
        hread(8'h04, 0, 32'h00005A00, "R11 R2 status");
        hread(8'h90, 0, 32'h0, "R11 rbuf");

        // R7 outbound buffer
        for (int k = 0; k < 4; k++) hwrite(8'h80 + 8'(4*k), 32'hA0B0C000 + 32'(k));
        for (int k = 0; k < 4; k++) begin
            c_wb_idx = 2'(k); #1;
            check(c_wb_word, 32'hA0B0C000 + 32'(k), "R7 wbuf slot");
        end
        hread(8'h84, 0, 32'h0, "R9 wbuf read zero");

        // R1 R3 accept
        b0 = n_bell;
        hwrite(8'h00, 32'h000831FF);
        settle();
        check(32'(n_bell - b0), 1, "R1 one doorbell");
        check(c_cmd, 32'h000831FF, "R1 cmd latched");
        hread(8'h04, 0, 32'h00005A31, "R1 R3 status busy");
        hread(8'h00, 0, 32'h0, "R9 cmd read zero");

        // R6 overrun
        b0 = n_bell;
        hwrite(8'h00, 32'h00007042);
        settle();
        check(32'(n_bell - b0), 0, "R6 no doorbell");
        check(c_cmd, 32'h000831FF, "R6 cmd kept");
        hread(8'h04, 0, 32'h00005A35, "R6 overrun status");

        // R8 R9 inbound buffer
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            c_rb_we = 1'b1; c_rb_idx = 2'(k);
            c_rb_wdata = (k == 0) ? 32'h11223344 : (k == 1) ? 32'h55667788 :
                         (k == 2) ? 32'h99AABBCC : 32'hDDEEFF00;
        end
        @(negedge clk); c_rb_we = 1'b0;
        hwrite(8'h94, 32'hDEADBEEF);
        hwrite(8'h04, 32'hFFFFFFFF);
        hread(8'h94, 0, 32'h55667788, "R9 R8 rbuf write ignored");
        hread(8'h04, 0, 32'h00005A35, "R9 status write ignored");
        hread(8'h9C, 0, 32'hDDEEFF00, "R8 word read");
        hread(8'h91, 1, 32'h00000033, "R8 byte lane1");
        hread(8'h9E, 1, 32'h000000EE, "R8 byte lane2");

        // R4 R5 completion with error and ioc
        i0 = n_irq;
        cdone(1, 8'h7E, 0, 0);
        settle();
        check(32'(n_irq - i0), 1, "R5 irq pulse");
        hread(8'h04, 0, 32'h007E5A36, "R4 status done");

        // R10 idle done
        i0 = n_irq;
        cdone(0, 8'h11, 0, 0);
        settle();
        check(32'(n_irq - i0), 0, "R10 no irq");
        hread(8'h04, 0, 32'h007E5A36, "R10 status unchanged");

        // R4 R5 command without ioc
        hwrite(8'h00, 32'h00049010);
        settle();
        hread(8'h04, 0, 32'h00005A95, "R4 R3 new cmd clears error");
        i0 = n_irq;
        cdone(0, 8'h00, 0, 0);
        settle();
        check(32'(n_irq - i0), 0, "R5 no irq without ioc");
        hread(8'h04, 0, 32'h00005A94, "R4 idle after done");

        // R12 done and command in one cycle
        hwrite(8'h00, 32'h000021AB);
        settle();
        hread(8'h04, 0, 32'h00005A25, "R12 busy before");
        b0 = n_bell; i0 = n_irq;
        cdone(0, 8'h22, 1, 32'h00006001);
        settle();
        check(32'(n_bell - b0), 0, "R12 no doorbell");
        check(32'(n_irq - i0), 1, "R12 irq");
        check(c_cmd, 32'h000021AB, "R12 cmd kept");
        hread(8'h04, 0, 32'h00225A24, "R12 status");

        settle();
        report();
    end
endmodule